// File: doc/BRIEF.md
# Interrupt Flag and Timebase Unit

This unit gathers event flags from neighbouring blocks into two 8-bit banks and raises one interrupt request line. Each bank has a write-one-to-clear status register and an enable register. The enable register selects which flags may drive the interrupt. Single-cycle event pulses from the serial, network, capture/compare, timer and stepper logic set their own flags. The unit itself generates four periodic timebase flags in bank A.

A clock-enable tick drives a prescaler. The prescaler advances a hundredths-of-a-second counter (0 to 99), and each wrap of that counter adds one to a 32-bit elapsed-seconds count. The timebase flags are taken from this same counter chain, so they mark 10 ms, 100 ms, 1 s and 10 s boundaries. Software reads the seconds count as a coherent snapshot: a read of the hundredths register freezes the seconds value, and the four byte registers then return that frozen copy. To load a new count, software writes the three lower bytes, which are held in staging, and then writes the top byte, which commits all 32 bits at once.

Registers sit on a simple synchronous bus. An access lasts one cycle while `bus_en` is high. Read data is combinational from register state.

Top module: `irq_tick_unit`

## Requirements
- R1: After reset, all flags, enables, the hundredths count, the seconds count and its snapshot are zero, and `irq` is low.
- R2: A pulse on `ev_bank_a[i]` sets flag A bit 4+i. A pulse on `ev_bank_b[i]` sets flag B bit i. Flag B bits 7..5 always read 0. The flag registers sit at bus addresses 2 (bank A) and 3 (bank B); enable A is at address 0 and enable B at address 1.
- R3: A write to a flag register clears every flag whose data bit is 1 and leaves the other flags unchanged.
- R4: If an event and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R5: `irq` is a register. It goes high one cycle after any flag is set together with its enable bit in either bank, and it stays low while no enabled flag is set.
- R6: Flag A bit 0 is set each time TICKS_PER_CS enabled ticks have completed one hundredth. The hundredths count advances at the same point.
- R7: Flag A bit 1 is set when the hundredths count steps from a value ending in 9. Flag A bit 2 is set when it wraps from 99 to 0. Flag A bit 3 is set on every tenth such wrap.
- R8: The hundredths count (address 4) runs 0 to 99. Its wrap increments the 32-bit seconds count by one.
- R9: A read of address 4 copies the live seconds count into a snapshot. Addresses 5..8 return snapshot bytes 0..3, least significant first, and do not follow the live count between captures.
- R10: Writes to addresses 5..7 only stage bytes 0..2. A write to address 8 loads the seconds count with {data, staged bytes} in one step.
- R11: A write to address 4 loads the hundredths count with the data when it is below 100, and with 0 otherwise.
- R12: While `tick_en` is low and no hundredths write occurs, the hundredths count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timebase clock-enable tick |
| ev_bank_a | input | 4 | Event pulses for flag A bits 7..4 (rx byte, tx full, message available, message sent) |
| ev_bank_b | input | 5 | Event pulses for flag B bits 4..0 (network timeout, timer overflow, stepper done, capture/compare 2, capture/compare 1) |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bound checker watches several rules on every cycle. It checks that the hundredths count stays within 0..99 and that the count is frozen when neither a tick nor a write occurs. It checks that an event beats a clear in the same cycle, that the unused bank-B bits stay zero, and that the interrupt rises only from an enabled flag and drops when none remains. The bench scenarios cover the remaining behaviour: the exact tick counts at which each of the four timebase flags appears, the snapshot holding a stale value until the next hundredths read, the staged byte loading of the seconds count, and the clamping of out-of-range hundredths writes.

// File: rtl/itb_pkg.sv
package itb_pkg;
    localparam int BANK_W = 8;
    localparam int HUND_W = 7;
    localparam int SEC_W  = 32;

    localparam logic [3:0] A_EN_A  = 4'd0;
    localparam logic [3:0] A_EN_B  = 4'd1;
    localparam logic [3:0] A_FLG_A = 4'd2;
    localparam logic [3:0] A_FLG_B = 4'd3;
    localparam logic [3:0] A_HUND  = 4'd4;
    localparam logic [3:0] A_SEC0  = 4'd5;
    localparam logic [3:0] A_SEC1  = 4'd6;
    localparam logic [3:0] A_SEC2  = 4'd7;
    localparam logic [3:0] A_SEC3  = 4'd8;

    localparam logic [HUND_W-1:0] HUND_LAST = 7'd99;
endpackage

// File: rtl/itb_clock.sv
module itb_clock
    import itb_pkg::*;
#(
    parameter int TICKS_PER_CS = 10000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                hund_we,
    input  logic [3:0]          sec_we,
    input  logic [7:0]          wdata,
    input  logic                capture,
    output logic [HUND_W-1:0]   hund_o,
    output logic [SEC_W-1:0]    snap_o,
    output logic [3:0]          tb_pulse_o
);
    localparam int PRE_W = $clog2(TICKS_PER_CS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_CS - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [HUND_W-1:0] hund;
        logic [SEC_W-1:0]  secs;
        logic [3:0]        dec;
        logic [23:0]       stage;
        logic [SEC_W-1:0]  snap;
    } clk_st_t;

    clk_st_t st_q, st_d;
    logic    cs_hit;
    logic    tenth_hit;
    logic    sec_hit;
    logic    dsec_hit;

    always_comb begin
        st_d      = st_q;
        cs_hit    = tick_en && (st_q.pre == PRE_LAST);
        tenth_hit = cs_hit && ((st_q.hund % 7'd10) == 7'd9);
        sec_hit   = cs_hit && (st_q.hund >= HUND_LAST);
        dsec_hit  = sec_hit && (st_q.dec == 4'd9);

        if (tick_en) begin
            st_d.pre = cs_hit ? '0 : st_q.pre + 1'b1;
        end

        if (hund_we) begin
            st_d.hund = (wdata < 8'd100) ? wdata[HUND_W-1:0] : '0;
        end else if (cs_hit) begin
            st_d.hund = sec_hit ? '0 : st_q.hund + 1'b1;
        end

        if (sec_hit) begin
            st_d.dec = (st_q.dec == 4'd9) ? 4'd0 : st_q.dec + 4'd1;
        end

        for (int k = 0; k < 3; k++) begin
            if (sec_we[k]) begin
                st_d.stage[8*k +: 8] = wdata;
            end
        end

        if (sec_we[3]) begin
            st_d.secs = {wdata, st_q.stage};
        end else if (sec_hit) begin
            st_d.secs = st_q.secs + 32'd1;
        end

        if (capture) begin
            st_d.snap = st_q.secs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hund_o     = st_q.hund;
    assign snap_o     = st_q.snap;
    assign tb_pulse_o = {dsec_hit, sec_hit, tenth_hit, cs_hit};
endmodule

// File: rtl/itb_flagbank.sv
module itb_flagbank #(
    parameter int          W    = 8,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic         en_we_i,
    input  logic [W-1:0] en_wdata_i,
    output logic [W-1:0] flags_o,
    output logic [W-1:0] en_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] flags;
        logic [W-1:0] en;
    } bank_st_t;

    bank_st_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.flags = ((st_q.flags & ~clr_i) | set_i) & IMPL;
        if (en_we_i) begin
            st_d.en = en_wdata_i & IMPL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
    assign en_o    = st_q.en;
    assign pend_o  = |(st_q.flags & st_q.en);
endmodule

// File: rtl/irq_tick_unit.sv
module irq_tick_unit
    import itb_pkg::*;
#(
    parameter int TICKS_PER_CS = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [3:0] ev_bank_a,
    input  logic [4:0] ev_bank_b,
    input  logic       bus_en,
    input  logic       bus_wr,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    localparam logic [BANK_W-1:0] IMPL_A = 8'hFF;
    localparam logic [BANK_W-1:0] IMPL_B = 8'h1F;

    logic              wr_en_a, wr_en_b, wr_flg_a, wr_flg_b, wr_hund, rd_hund;
    logic [3:0]        wr_sec;
    logic [BANK_W-1:0] clr_a, clr_b, set_a, set_b;
    logic [BANK_W-1:0] flags_a, flags_b, en_a, en_b;
    logic              pend_a, pend_b;
    logic [HUND_W-1:0] hund;
    logic [SEC_W-1:0]  snap;
    logic [3:0]        tb_pulse;
    logic              irq_d, irq_q;

    always_comb begin
        wr_en_a  = bus_en && bus_wr && (bus_addr == A_EN_A);
        wr_en_b  = bus_en && bus_wr && (bus_addr == A_EN_B);
        wr_flg_a = bus_en && bus_wr && (bus_addr == A_FLG_A);
        wr_flg_b = bus_en && bus_wr && (bus_addr == A_FLG_B);
        wr_hund  = bus_en && bus_wr && (bus_addr == A_HUND);
        rd_hund  = bus_en && !bus_wr && (bus_addr == A_HUND);
        for (int k = 0; k < 4; k++) begin
            wr_sec[k] = bus_en && bus_wr && (bus_addr == A_SEC0 + 4'(k));
        end
        clr_a = wr_flg_a ? bus_wdata : '0;
        clr_b = wr_flg_b ? bus_wdata : '0;
        set_a = {ev_bank_a, tb_pulse};
        set_b = {3'b000, ev_bank_b};
    end

    itb_clock #(
        .TICKS_PER_CS(TICKS_PER_CS)
    ) u_clock (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .hund_we    (wr_hund),
        .sec_we     (wr_sec),
        .wdata      (bus_wdata),
        .capture    (rd_hund),
        .hund_o     (hund),
        .snap_o     (snap),
        .tb_pulse_o (tb_pulse)
    );

    itb_flagbank #(.W(BANK_W), .IMPL(IMPL_A)) u_bank_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_a),
        .clr_i      (clr_a),
        .en_we_i    (wr_en_a),
        .en_wdata_i (bus_wdata),
        .flags_o    (flags_a),
        .en_o       (en_a),
        .pend_o     (pend_a)
    );

    itb_flagbank #(.W(BANK_W), .IMPL(IMPL_B)) u_bank_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_b),
        .clr_i      (clr_b),
        .en_we_i    (wr_en_b),
        .en_wdata_i (bus_wdata),
        .flags_o    (flags_b),
        .en_o       (en_b),
        .pend_o     (pend_b)
    );

    always_comb begin
        irq_d = pend_a || pend_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q;

    always_comb begin
        case (bus_addr)
            A_EN_A:  bus_rdata = en_a;
            A_EN_B:  bus_rdata = en_b;
            A_FLG_A: bus_rdata = flags_a;
            A_FLG_B: bus_rdata = flags_b;
            A_HUND:  bus_rdata = {1'b0, hund};
            A_SEC0:  bus_rdata = snap[7:0];
            A_SEC1:  bus_rdata = snap[15:8];
            A_SEC2:  bus_rdata = snap[23:16];
            A_SEC3:  bus_rdata = snap[31:24];
            default: bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/itb_checks.sv
module itb_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_en,
    input logic       wr_hund,
    input logic [4:0] ev_bank_b,
    input logic [7:0] flags_a,
    input logic [7:0] en_a,
    input logic [7:0] flags_b,
    input logic [7:0] en_b,
    input logic [6:0] hund,
    input logic       irq
);
    a_r8_hund_range: assert property (@(posedge clk) disable iff (!rst_n)
        hund <= 7'd99);

    a_r12_hund_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_hund) |=> $stable(hund));

    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_bank_b) |=> ((flags_b[4:0] & $past(ev_bank_b)) == $past(ev_bank_b)));

    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flags_b[7:5] == 3'b000);

    a_r5_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(((flags_a & en_a) != 8'h00) || ((flags_b & en_b) != 8'h00)));

    a_r5_masked_low: assert property (@(posedge clk) disable iff (!rst_n)
        (((flags_a & en_a) == 8'h00) && ((flags_b & en_b) == 8'h00)) |=> !irq);
endmodule

bind irq_tick_unit itb_checks u_itb_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wr_hund   (wr_hund),
    .ev_bank_b (ev_bank_b),
    .flags_a   (flags_a),
    .en_a      (en_a),
    .flags_b   (flags_b),
    .en_b      (en_b),
    .hund      (hund),
    .irq       (irq)
);

// File: tb/test_irq_tick_unit.sv
module test_irq_tick_unit;
    localparam int TPC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [3:0] ev_bank_a = '0;
    logic [4:0] ev_bank_b = '0;
    logic       bus_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t cur;

    always #4 clk = ~clk;

    irq_tick_unit #(.TICKS_PER_CS(TPC)) i_irq_tick_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .ev_bank_a (ev_bank_a),
        .ev_bank_b (ev_bank_b),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        if (bus_en && !bus_wr) begin
            tests++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: read with no expected item, actual %02h", bus_rdata);
            end else begin
                cur = sb_q.pop_front();
                if (bus_rdata !== cur.exp) begin
                    fails++;
                    $display("FAIL %s: addr %0d actual %02h expected %02h",
                             cur.tag, bus_addr, bus_rdata, cur.exp);
                end
            end
        end
    end

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        it.exp = e;
        it.tag = tag;
        @(posedge clk); #1;
        sb_q.push_back(it);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        @(posedge clk); #1;
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        tick_en = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        repeat (2) @(posedge clk);
        @(negedge clk);
        tests++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq actual %0b expected %0b", tag, irq, e);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, 8'h00, "R1 enable A");
        rd(4'd1, 8'h00, "R1 enable B");
        rd(4'd2, 8'h00, "R1 flags A");
        rd(4'd3, 8'h00, "R1 flags B");
        rd(4'd4, 8'h00, "R1 hundredths");
        rd(4'd8, 8'h00, "R1 seconds byte 3");
        check_irq(1'b0, "R1 irq");

        // R2 event pulses set flags
        @(posedge clk); #1 ev_bank_a = 4'b0101;
        @(posedge clk); #1 ev_bank_a = 4'b0000;
        rd(4'd2, 8'h50, "R2 bank A events");
        @(posedge clk); #1 ev_bank_b = 5'b11111;
        @(posedge clk); #1 ev_bank_b = 5'b00000;
        rd(4'd3, 8'h1F, "R2 bank B events, top bits zero");
        check_irq(1'b0, "R5 no enable no irq");

        // R5 enable path
        wr(4'd1, 8'h02);
        check_irq(1'b1, "R5 enabled flag raises irq");
        wr(4'd3, 8'h02);
        check_irq(1'b0, "R5 irq drops after clear");

        // R3 write-one-to-clear
        wr(4'd2, 8'h10);
        rd(4'd2, 8'h40, "R3 partial clear bank A");
        wr(4'd3, 8'h1D);
        rd(4'd3, 8'h00, "R3 full clear bank B");
        wr(4'd2, 8'hFF);

        // R4 event beats clear
        @(posedge clk); #1;
        ev_bank_b = 5'b00001;
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = 8'h01;
        @(posedge clk); #1;
        ev_bank_b = 5'b00000; bus_en = 1'b0; bus_wr = 1'b0;
        rd(4'd3, 8'h01, "R4 event and clear same cycle");
        wr(4'd3, 8'hFF);
        wr(4'd1, 8'h00);

        // R6 hundredths flag
        run_ticks(1);
        rd(4'd2, 8'h00, "R6 no flag before full hundredth");
        run_ticks(1);
        rd(4'd2, 8'h01, "R6 hundredth flag");
        rd(4'd4, 8'h01, "R6 hundredths advanced");
        wr(4'd2, 8'hFF);

        // R7 tenth flag
        run_ticks(17);
        rd(4'd2, 8'h01, "R7 no tenth flag before boundary");
        run_ticks(1);
        rd(4'd2, 8'h03, "R7 tenth flag");
        wr(4'd2, 8'hFF);

        // R8/R9 seconds carry and snapshot
        run_ticks(179);
        rd(4'd4, 8'd99, "R8 hundredths at 99");
        rd(4'd5, 8'h00, "R9 snapshot before carry");
        run_ticks(1);
        rd(4'd2, 8'h07, "R7 second flag");
        rd(4'd4, 8'd0, "R8 hundredths wrapped");
        rd(4'd5, 8'h01, "R8 seconds incremented");

        run_ticks(200);
        rd(4'd5, 8'h01, "R9 snapshot stale until capture");
        rd(4'd4, 8'd0, "R9 capture read");
        rd(4'd5, 8'h02, "R9 snapshot refreshed");

        // R7 ten-second flag
        wr(4'd2, 8'hFF);
        run_ticks(1599);
        rd(4'd2, 8'h07, "R7 no ten-second flag early");
        run_ticks(1);
        rd(4'd2, 8'h0F, "R7 ten-second flag");
        rd(4'd4, 8'd0, "R8 capture at ten seconds");
        rd(4'd5, 8'd10, "R8 seconds at ten");

        // R5 bank A enable
        wr(4'd0, 8'h08);
        check_irq(1'b1, "R5 bank A enabled flag");
        wr(4'd0, 8'h00);

        // R10 staged load
        wr(4'd5, 8'h44);
        wr(4'd6, 8'h33);
        wr(4'd7, 8'h22);
        rd(4'd4, 8'd0, "R10 capture after staging");
        rd(4'd5, 8'd10, "R10 staging alone does not load");
        wr(4'd8, 8'h11);
        rd(4'd4, 8'd0, "R10 capture after load");
        rd(4'd5, 8'h44, "R10 byte 0");
        rd(4'd6, 8'h33, "R10 byte 1");
        rd(4'd7, 8'h22, "R10 byte 2");
        rd(4'd8, 8'h11, "R10 byte 3");

        // R11 hundredths write
        wr(4'd4, 8'd50);
        rd(4'd4, 8'd50, "R11 hundredths load");
        wr(4'd4, 8'd150);
        rd(4'd4, 8'd0, "R11 out of range load");
        wr(4'd4, 8'd37);

        // R12 hold while idle
        repeat (20) @(posedge clk);
        rd(4'd4, 8'd37, "R12 hundredths held without tick");

        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule